// File: doc/BRIEF.md
# Breakpoint Request and Serial Debug Clock Pin Driver

This host-side block drives a single shared line toward a target processor. Before the target enters its background debug state, the line is a breakpoint request. There are two ways to raise it. A tag input pulls the line low for as many cycles as the tag is held, and does not latch. A force input sets a request latch that holds the line low until the target shows it has halted by raising its freeze output. A force input can be a one-cycle pulse or can stay high until freeze is seen, and both give the same result.

Once freeze is high, the same line becomes the serial clock of a 17-bit shifter. The shifter sends the most significant bit first and shifts data in from the target at the same time. The first low phase of the serial clock releases the request latch. The line goes back high after the last rising edge and stays high, so the next bus cycle after the debug session is not tagged by mistake. The half period of the serial clock is set in system clock cycles.

Top module: `bkpt_sclk_drv`

## Requirements
- R1: While rst_ni is low, and after it is released with no other input active, pin_o is 1, busy_o is 0 and done_o is 0. Asserting rst_ni clears a held force request at once.
- R2: A force_i high in any cycle with freeze_i low makes pin_o 0 from the next cycle on. pin_o stays 0 until a transfer is accepted. This is the same whether force_i was high for one cycle or stayed high until freeze_i rose.
- R3: A force_i pulse while freeze_i is high leaves pin_o at 1.
- R4: For each cycle in which tag_i is high, pin_o is 0 in the following cycle. pin_o returns to 1 after that with no latched request left behind.
- R5: A start_i is accepted only when freeze_i is 1 and busy_o is 0. Otherwise it is ignored and the data being sent is not changed.
- R6: A transfer sends the 17 bits of data_i on sdo_o, bit 16 first. Each bit is stable on sdo_o for its whole clock low phase and across the following rising edge of pin_o.
- R7: Each serial clock phase, low and high, lasts H system cycles, where H is half_i captured at acceptance. A value of 0 is treated as 1. A transfer therefore keeps pin_o low for 17*H cycles.
- R8: After the last rising edge of a transfer, pin_o stays at 1 until a new request or transfer.
- R9: busy_o is 1 from the cycle after acceptance until the last rising edge of the serial clock, for exactly 33*H cycles.
- R10: done_o is a one-cycle pulse in the cycle busy_o falls. rx_o then holds the 17 sdi_i values sampled at the rising edges, the first one in bit 16.
- R11: The first serial clock low phase releases the force latch. The line is then high during every high phase of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| force_i | input | 1 | Force entry into debug state (latched) |
| tag_i | input | 1 | Mark the current bus cycle for a breakpoint |
| freeze_i | input | 1 | Target halted indication |
| start_i | input | 1 | Start a serial transfer |
| data_i | input | 17 | Word to send |
| half_i | input | 8 | Serial clock half period in system cycles |
| sdi_i | input | 1 | Serial data from the target |
| pin_o | output | 1 | Shared breakpoint / serial clock line, idle high |
| sdo_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Final bit captured |
| rx_o | output | 17 | Word received from the target |

## Verification
The force request and the start of the serial clock can meet on the line in the same cycle. The latch must then hand the low level over to the first clock phase without a high glitch, and must not stay set into the high phases. The bench provokes this with a force that is still held when freeze rises, followed by a transfer started as soon as freeze is high. It judges the result by counting the low cycles during the transfer, which must be exactly 17*H, and by checking that the line is high at every high phase and after the last edge.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} sclk_ph_e;
endpackage

// File: rtl/bkpt_req_latch.sv
module bkpt_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic tag_i,
  output logic hold_o
);
  logic latch_q, tag_q;

  // clear has priority; set and clear are disjoint by freeze in practice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      tag_q   <= 1'b0;
    end else begin
      tag_q <= tag_i;
      if (clr_i)      latch_q <= 1'b0;
      else if (set_i) latch_q <= 1'b1;
    end
  end

  assign hold_o = latch_q | tag_q;
endmodule

// File: rtl/bkpt_ser_shift.sv
module bkpt_ser_shift
  import bkpt_pkg::*;
#(
  parameter int DW    = 17,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    data_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             sdi_i,
  output logic             sclk_lo_o,
  output logic             sdo_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rx_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  sclk_ph_e         ph_q;
  logic             busy_q, done_q;
  logic [DIV_W-1:0] div_q, half_q;
  logic [CW-1:0]    bit_q;
  logic [DW-1:0]    sh_q, rx_q;
  logic [DIV_W-1:0] half_eff;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_HI;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      half_q <= DIV_W'(1);
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        ph_q   <= PH_LO;
        div_q  <= '0;
        bit_q  <= '0;
        sh_q   <= data_i;
        half_q <= half_eff;
      end else if (busy_q) begin
        if (div_q == half_q - DIV_W'(1)) begin
          div_q <= '0;
          if (ph_q == PH_LO) begin
            ph_q <= PH_HI;                   // rising edge: capture
            rx_q <= {rx_q[DW-2:0], sdi_i};
            if (bit_q == LAST) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + CW'(1);
            end
          end else begin
            ph_q <= PH_LO;                   // falling edge: next bit
            sh_q <= {sh_q[DW-2:0], 1'b0};
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign sclk_lo_o = busy_q && (ph_q == PH_LO);
  assign sdo_o     = sh_q[DW-1];
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_o      = rx_q;
endmodule

// File: rtl/bkpt_sclk_drv.sv
module bkpt_sclk_drv #(
  parameter int DW    = 17,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_i,
  input  logic             tag_i,
  input  logic             freeze_i,
  input  logic             start_i,
  input  logic [DW-1:0]    data_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             sdi_i,
  output logic             pin_o,
  output logic             sdo_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rx_o
);
  logic start_ok, req_set, hold, sclk_lo, busy;

  assign start_ok = start_i & freeze_i & ~busy;
  assign req_set  = force_i & ~freeze_i;

  bkpt_req_latch i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set),
    .clr_i  (start_ok),
    .tag_i  (tag_i),
    .hold_o (hold)
  );

  bkpt_ser_shift #(.DW(DW), .DIV_W(DIV_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_ok),
    .data_i    (data_i),
    .half_i    (half_i),
    .sdi_i     (sdi_i),
    .sclk_lo_o (sclk_lo),
    .sdo_o     (sdo_o),
    .busy_o    (busy),
    .done_o    (done_o),
    .rx_o      (rx_o)
  );

  assign busy_o = busy;
  assign pin_o  = ~(hold | sclk_lo);
endmodule

// File: rtl/bkpt_sclk_drv_chk.sv
module bkpt_sclk_drv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic force_i,
  input logic tag_i,
  input logic freeze_i,
  input logic start_i,
  input logic pin_o,
  input logic sdo_o,
  input logic busy_o,
  input logic done_o
);
  p_force_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i && !freeze_i |=> !pin_o);
  p_tag_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_i |=> !pin_o);
  p_start_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !freeze_i && !busy_o |=> !busy_o);
  p_sdo_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_o) && ($past(busy_o) || busy_o) |-> $stable(sdo_o));
  p_idle_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> pin_o);
  p_done_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bkpt_sclk_drv bkpt_sclk_drv_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .force_i  (force_i),
  .tag_i    (tag_i),
  .freeze_i (freeze_i),
  .start_i  (start_i),
  .pin_o    (pin_o),
  .sdo_o    (sdo_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/test_bkpt_sclk_drv.sv
module test_bkpt_sclk_drv;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 17;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic force_i = 0, tag_i = 0, freeze_i = 0, start_i = 0;
  logic [DW-1:0] data_i = '0;
  logic [7:0] half_i = 8'd1;
  logic pin_o, sdo_o, busy_o, done_o;
  logic [DW-1:0] rx_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_sclk_drv i_bkpt_sclk_drv (
    .clk_i(clk), .rst_ni(rst_ni), .force_i(force_i), .tag_i(tag_i),
    .freeze_i(freeze_i), .start_i(start_i), .data_i(data_i), .half_i(half_i),
    .sdi_i(sdo_o), .pin_o(pin_o), .sdo_o(sdo_o), .busy_o(busy_o),
    .done_o(done_o), .rx_o(rx_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // transfer with loopback; retrig re-issues start with other data while busy
  task automatic xfer(input logic [DW-1:0] d, input int h, input bit retrig);
    int heff = (h == 0) ? 1 : h;
    int bcnt = 0, lcnt = 0, k = 0;
    logic ppin, psdo;
    freeze_i = 1; start_i = 1; data_i = d; half_i = 8'(h);
    step(1);
    start_i = 0;
    if (retrig) begin start_i = 1; data_i = ~d; end
    do begin
      if (busy_o) bcnt++;
      if (!pin_o) lcnt++;
      ppin = pin_o; psdo = sdo_o;
      step(1);
      start_i = 0;
      if (!ppin && pin_o) begin
        if (k < DW) chk("R6 bit order", 32'(psdo), 32'(d[DW-1-k]));
        chk("R6 sdo stable across rise", 32'(sdo_o), 32'(psdo));
        k++;
      end
    end while (busy_o);
    chk("R6 bit count", 32'(k), 32'(DW));
    chk("R7 low cycles", 32'(lcnt), 32'(DW * heff));
    chk("R9 busy cycles", 32'(bcnt), 32'((2*DW - 1) * heff));
    chk("R10 done at busy fall", 32'(done_o), 32'd1);
    chk(retrig ? "R5 rx unchanged by start while busy" : "R10 rx word", 32'(rx_o), 32'(d));
    chk("R8 idle high after last rise", 32'(pin_o), 32'd1);
    step(1);
    chk("R10 done single pulse", 32'(done_o), 32'd0);
    step(2);
    chk("R8 stays high", 32'(pin_o), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] pats [6] = '{17'h00000, 17'h1FFFF, 17'h10000, 17'h00001, 17'h0A5A5, 17'h15555};
    step(2);
    chk("R1 pin in reset", 32'(pin_o), 32'd1);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    rst_ni = 1; step(2);
    chk("R1 pin after reset", 32'(pin_o), 32'd1);
    chk("R1 done after reset", 32'(done_o), 32'd0);

    // pulsed force
    force_i = 1; step(1); force_i = 0;
    chk("R2 pulsed force low", 32'(pin_o), 32'd0);
    step(4);
    chk("R2 pulsed force held", 32'(pin_o), 32'd0);
    freeze_i = 1; step(2);
    chk("R2 held after freeze", 32'(pin_o), 32'd0);
    xfer(17'h1A5C3, 2, 0);   // R11 via low-cycle count
    freeze_i = 0; step(1);

    // held force, freeze rises while force still high; start same cycle
    force_i = 1; step(3);
    chk("R2 held force low", 32'(pin_o), 32'd0);
    freeze_i = 1; step(1);
    chk("R2 held force at freeze", 32'(pin_o), 32'd0);
    force_i = 0;
    xfer(17'h0F0F1, 3, 0);   // R11 latch released at first low phase
    freeze_i = 0; step(1);

    // force ignored while frozen
    freeze_i = 1; force_i = 1; step(1); force_i = 0;
    chk("R3 force while frozen", 32'(pin_o), 32'd1);
    step(3);
    chk("R3 still high", 32'(pin_o), 32'd1);
    freeze_i = 0; step(1);

    // tag one cycle and two cycles
    tag_i = 1; step(1); tag_i = 0;
    chk("R4 tag low", 32'(pin_o), 32'd0);
    step(1);
    chk("R4 tag released", 32'(pin_o), 32'd1);
    tag_i = 1; step(2); tag_i = 0;
    chk("R4 tag two cycles", 32'(pin_o), 32'd0);
    step(1);
    chk("R4 tag no latch", 32'(pin_o), 32'd1);
    step(3);
    chk("R4 stays high", 32'(pin_o), 32'd1);

    // start refused without freeze
    freeze_i = 0; start_i = 1; data_i = 17'h1; step(1); start_i = 0;
    chk("R5 start refused no freeze", 32'(busy_o), 32'd0);
    chk("R5 pin idle", 32'(pin_o), 32'd1);

    // reset during held request
    force_i = 1; step(1); force_i = 0;
    chk("R2 low before reset", 32'(pin_o), 32'd0);
    #(CLK_PERIOD/4) rst_ni = 0; #1;
    chk("R1 reset clears latch", 32'(pin_o), 32'd1);
    step(1); rst_ni = 1; step(2);
    chk("R1 high after reset release", 32'(pin_o), 32'd1);

    // start while busy ignored
    xfer(17'h12345, 1, 1);

    // sweep half period and patterns
    for (int h = 0; h <= 4; h++)
      for (int p = 0; p < 6; p++)
        xfer(pats[p], h, 0);

    summary();
  end
endmodule